// File: doc/BRIEF.md
# Graded Power-Mode Sequencer

This block takes a chip through four nested power modes on request from software. Mode 0 is active, mode 1 is doze, mode 2 is nap and mode 3 is sleep. Each mode switches off everything the mode above it switches off, and then more. A write into the mode request register is presented as a one-cycle `req_valid` pulse with a 2-bit `req_mode`. The block then walks the control outputs through a fixed order of steps, one mode level at a time, until it reaches the target. While it does this it reports `busy`. It updates `cur_mode` only when the whole walk has finished.

The clock controller, the supply regulator and the core power switches are outside the block. Each of them answers a step with a one-cycle acknowledge pulse: `clk_ack` for clock changes and `pwr_ack` for supply changes. Both acknowledges pass through a `SYNC_STAGES`-flop synchronizer before the sequencer sees them. Going down into sleep, the block clamps the outputs of the gated domain, saves the retained state and then opens the core switch. Coming back up, it closes the switch, waits for the rush current to settle for a programmable number of cycles, restores the state and only then removes the clamps.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in mode 0 (active). `core_clk_en`, `pll_en`, `snoop_en` and `core_sw_en` are 1. `lowv_req`, `iso_en`, `ret_save`, `ret_restore` and `busy` are 0. Mode codes are: 0 active, 1 doze, 2 nap, 3 sleep.
- R2: Stepping from mode 0 to mode 1 clears only `core_clk_en`. The sequencer then waits for `clk_ack`.
- R3: Stepping from mode 1 to mode 2 clears `pll_en` and `snoop_en` together. After `clk_ack` it raises `lowv_req` and waits for `pwr_ack`.
- R4: Stepping from mode 2 to mode 3 proceeds in this order, each change in its own cycle:
  - `iso_en` rises.
  - `ret_save` pulses high for exactly one cycle.
  - `core_sw_en` falls in the cycle the save pulse ends.
  - The step then waits for `pwr_ack`.
  - `core_sw_en` is never 0 while `iso_en` is 0.
- R5: Stepping up reverses the down steps:
  - `core_sw_en` rises first.
  - `ret_restore` pulses for one cycle.
  - `iso_en` falls in the cycle the restore pulse ends.
  - Leaving nap drops `lowv_req`, then after `pwr_ack` raises `pll_en` and `snoop_en`.
  - Leaving doze raises `core_clk_en`, then waits for `clk_ack`.
- R6: During wake from sleep, `ret_restore` rises exactly `settle_cycles + SYNC_STAGES + 2` clock cycles after the cycle in which the `pwr_ack` pulse for the switch closing is presented. A `settle_cycles` of 0 is allowed.
- R7: The sequence does not move past a clock step until a `clk_ack` pulse arrives, and does not move past a supply step until a `pwr_ack` pulse arrives.
- R8: `busy` rises in the cycle after an accepted request and stays high until the walk completes. `cur_mode` takes the target value in the same cycle that `busy` falls, and at no other time.
- R9: The block ignores a request that arrives while `busy` is high, and ignores a request for the mode it is already in. Neither kind of request produces any change at the outputs.
- R10: A request may name any mode from any mode. A multi-level change passes through every intermediate step in order without pausing and without reporting the intermediate modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle strobe from the mode request register |
| req_mode | input | 2 | Requested mode code |
| settle_cycles | input | SETTLE_W | Rush-current settle time in cycles |
| clk_ack | input | 1 | Pulse: clock controller reached commanded state |
| pwr_ack | input | 1 | Pulse: supply or switch reached commanded state |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_en | output | 1 | Bus-snoop logic enable |
| lowv_req | output | 1 | Request for reduced core supply voltage |
| core_sw_en | output | 1 | Core power switch closed when 1 |
| iso_en | output | 1 | Clamp the gated domain's outputs |
| ret_save | output | 1 | One-cycle retention save strobe |
| ret_restore | output | 1 | One-cycle retention restore strobe |
| cur_mode | output | 2 | Mode the block currently sits in |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions take three things for granted about the inputs:
- Every acknowledge is a single-cycle pulse, and it arrives only while the matching step is pending.
- `settle_cycles` does not change during a wake.
- `req_valid` is a strobe.

The stimulus keeps within these assumptions in three ways. An acknowledge responder raises exactly one pulse, after a chosen delay, for each change it sees on a clock or supply output. `settle_cycles` is changed only while the block is idle. Requests are one-cycle pulses driven between clock edges.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'd0,
      MODE_DOZE   = 2'd1,
      MODE_NAP    = 2'd2,
      MODE_SLEEP  = 2'd3
   } pwr_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PICK,
      ST_DN_CORE,
      ST_DN_PLL,
      ST_DN_VLOW,
      ST_DN_ISO,
      ST_DN_SAVE,
      ST_DN_SW,
      ST_UP_SW,
      ST_UP_SETTLE,
      ST_UP_RESTORE,
      ST_UP_VNOM,
      ST_UP_PLL,
      ST_UP_CORE
   } seq_state_e;

   typedef struct packed {
      logic core_clk_en;
      logic pll_en;
      logic snoop_en;
      logic lowv_req;
      logic core_sw_en;
      logic iso_en;
      logic ret_save;
      logic ret_restore;
   } pwr_ctl_t;

   localparam pwr_ctl_t CTL_RESET = '{
      core_clk_en: 1'b1,
      pll_en:      1'b1,
      snoop_en:    1'b1,
      lowv_req:    1'b0,
      core_sw_en:  1'b1,
      iso_en:      1'b0,
      ret_save:    1'b0,
      ret_restore: 1'b0
   };

endpackage

// File: rtl/pwr_ack_sync.sv
module pwr_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("pwr_ack_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else if (STAGES == 1) begin : g_one
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= 1'b0;
         else        ff_q <= d;
      end
      assign q = ff_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
   end

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] load,
   output logic         done
);

   if (W < 1 || W > 24) begin : g_bad_width
      $error("pwr_settle_timer: W must lie in 1..24");
   end

   logic [W-1:0] cnt_q;
   logic         run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= load;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = run_q && (cnt_q == '0);

   // R6: a nonzero settle time never finishes in the cycle after it starts
   a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      (start && load != '0) |=> !done);

   // R6: completion is reported for a single cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_seq_pkg::*;
#(
   parameter int SETTLE_W    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                clk_ack,
   input  logic                pwr_ack,
   output logic                core_clk_en,
   output logic                pll_en,
   output logic                snoop_en,
   output logic                lowv_req,
   output logic                core_sw_en,
   output logic                iso_en,
   output logic                ret_save,
   output logic                ret_restore,
   output logic [1:0]          cur_mode,
   output logic                busy
);

   if (SETTLE_W < 1 || SETTLE_W > 24) begin : g_bad_settle
      $error("pwr_mode_seq: SETTLE_W must lie in 1..24");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("pwr_mode_seq: SYNC_STAGES must lie in 0..4");
   end

   logic clk_ack_s;
   logic pwr_ack_s;

   pwr_ack_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (clk_ack),
      .q     (clk_ack_s)
   );

   pwr_ack_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pwr_ack),
      .q     (pwr_ack_s)
   );

   seq_state_e        st_q;
   pwr_ctl_t          ctl_q;
   logic [MODE_W-1:0] lvl_q;
   logic [MODE_W-1:0] tgt_q;
   logic [MODE_W-1:0] mode_q;
   logic              busy_q;
   logic              settle_start;
   logic              settle_done;

   assign settle_start = (st_q == ST_UP_SW) && pwr_ack_s;

   pwr_settle_timer #(.W(SETTLE_W)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .start (settle_start),
      .load  (settle_cycles),
      .done  (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctl_q  <= CTL_RESET;
         lvl_q  <= MODE_ACTIVE;
         tgt_q  <= MODE_ACTIVE;
         mode_q <= MODE_ACTIVE;
         busy_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid && (req_mode != mode_q)) begin
                  tgt_q  <= req_mode;
                  busy_q <= 1'b1;
                  st_q   <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (lvl_q < tgt_q) begin
                  case (lvl_q)
                     MODE_ACTIVE: begin
                        ctl_q.core_clk_en <= 1'b0;
                        st_q              <= ST_DN_CORE;
                     end
                     MODE_DOZE: begin
                        ctl_q.pll_en   <= 1'b0;
                        ctl_q.snoop_en <= 1'b0;
                        st_q           <= ST_DN_PLL;
                     end
                     default: begin
                        ctl_q.iso_en <= 1'b1;
                        st_q         <= ST_DN_ISO;
                     end
                  endcase
               end else if (lvl_q > tgt_q) begin
                  case (lvl_q)
                     MODE_SLEEP: begin
                        ctl_q.core_sw_en <= 1'b1;
                        st_q             <= ST_UP_SW;
                     end
                     MODE_NAP: begin
                        ctl_q.lowv_req <= 1'b0;
                        st_q           <= ST_UP_VNOM;
                     end
                     default: begin
                        ctl_q.core_clk_en <= 1'b1;
                        st_q              <= ST_UP_CORE;
                     end
                  endcase
               end else begin
                  mode_q <= tgt_q;
                  busy_q <= 1'b0;
                  st_q   <= ST_IDLE;
               end
            end
            ST_DN_CORE: begin
               if (clk_ack_s) begin
                  lvl_q <= MODE_DOZE;
                  st_q  <= ST_PICK;
               end
            end
            ST_DN_PLL: begin
               if (clk_ack_s) begin
                  ctl_q.lowv_req <= 1'b1;
                  st_q           <= ST_DN_VLOW;
               end
            end
            ST_DN_VLOW: begin
               if (pwr_ack_s) begin
                  lvl_q <= MODE_NAP;
                  st_q  <= ST_PICK;
               end
            end
            ST_DN_ISO: begin
               ctl_q.ret_save <= 1'b1;
               st_q           <= ST_DN_SAVE;
            end
            ST_DN_SAVE: begin
               ctl_q.ret_save   <= 1'b0;
               ctl_q.core_sw_en <= 1'b0;
               st_q             <= ST_DN_SW;
            end
            ST_DN_SW: begin
               if (pwr_ack_s) begin
                  lvl_q <= MODE_SLEEP;
                  st_q  <= ST_PICK;
               end
            end
            ST_UP_SW: begin
               if (pwr_ack_s) st_q <= ST_UP_SETTLE;
            end
            ST_UP_SETTLE: begin
               if (settle_done) begin
                  ctl_q.ret_restore <= 1'b1;
                  st_q              <= ST_UP_RESTORE;
               end
            end
            ST_UP_RESTORE: begin
               ctl_q.ret_restore <= 1'b0;
               ctl_q.iso_en      <= 1'b0;
               lvl_q             <= MODE_NAP;
               st_q              <= ST_PICK;
            end
            ST_UP_VNOM: begin
               if (pwr_ack_s) begin
                  ctl_q.pll_en   <= 1'b1;
                  ctl_q.snoop_en <= 1'b1;
                  st_q           <= ST_UP_PLL;
               end
            end
            ST_UP_PLL: begin
               if (clk_ack_s) begin
                  lvl_q <= MODE_DOZE;
                  st_q  <= ST_PICK;
               end
            end
            ST_UP_CORE: begin
               if (clk_ack_s) begin
                  lvl_q <= MODE_ACTIVE;
                  st_q  <= ST_PICK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign core_clk_en = ctl_q.core_clk_en;
   assign pll_en      = ctl_q.pll_en;
   assign snoop_en    = ctl_q.snoop_en;
   assign lowv_req    = ctl_q.lowv_req;
   assign core_sw_en  = ctl_q.core_sw_en;
   assign iso_en      = ctl_q.iso_en;
   assign ret_save    = ctl_q.ret_save;
   assign ret_restore = ctl_q.ret_restore;
   assign cur_mode    = mode_q;
   assign busy        = busy_q;

   // R2: the PLL never runs down while the core clock still runs
   a_r2_core_before_pll: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> !core_clk_en);

   // R3: a lowered supply is only asked for with PLL and snooping stopped
   a_r3_lowv_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
      lowv_req |-> (!pll_en && !snoop_en));

   // R4: an open core switch always has its outputs clamped
   a_r4_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !core_sw_en |-> iso_en);

   // R4: the save strobe lasts a single cycle
   a_r4_save_single: assert property (@(posedge clk) disable iff (!rst_n)
      ret_save |=> !ret_save);

   // R4: the switch opens right after the save strobe
   a_r4_open_after_save: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_sw_en) |-> $past(ret_save));

   // R5: the restore strobe lasts a single cycle
   a_r5_restore_single: assert property (@(posedge clk) disable iff (!rst_n)
      ret_restore |=> !ret_restore);

   // R5: clamps come off only right after the restore
   a_r5_iso_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> $past(ret_restore));

   // R6: restore follows a completed settle count
   a_r6_restore_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ret_restore) |-> $past(settle_done));

   // R7: supply step holds until its acknowledge
   a_r7_wait_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DN_SW && !pwr_ack_s) |=> (st_q == ST_DN_SW));

   // R7: clock step holds until its acknowledge
   a_r7_wait_core: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DN_CORE && !clk_ack_s) |=> (st_q == ST_DN_CORE));

   // R8: the reported mode moves only when busy drops
   a_r8_mode_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_mode) |-> $fell(busy));

   // R9: a request during a sequence leaves the target alone
   a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(tgt_q));

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

   localparam int SETTLE_W = 8;
   localparam int SYNC     = 2;

   typedef struct {
      logic [11:0] vec;
      string       tag;
   } ev_t;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                req_valid;
   logic [1:0]          req_mode;
   logic [SETTLE_W-1:0] settle_val;
   logic                clk_ack;
   logic                pwr_ack;
   logic core_clk_en, pll_en, snoop_en, lowv_req, core_sw_en, iso_en, ret_save, ret_restore;
   logic [1:0]          cur_mode;
   logic                busy;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   int ack_dly  = 3;
   int sw_ack_cyc = 0;
   bit mon_en   = 1'b0;
   bit finished = 1'b0;
   ev_t evq[$];

   // bench model of the observable outputs
   logic [1:0] m_mode;
   logic m_busy, m_core, m_pll, m_snoop, m_lowv, m_sw, m_iso, m_save, m_rest;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwr_mode_seq #(.SETTLE_W(SETTLE_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .settle_cycles(settle_val), .clk_ack(clk_ack), .pwr_ack(pwr_ack),
      .core_clk_en(core_clk_en), .pll_en(pll_en), .snoop_en(snoop_en),
      .lowv_req(lowv_req), .core_sw_en(core_sw_en), .iso_en(iso_en),
      .ret_save(ret_save), .ret_restore(ret_restore), .cur_mode(cur_mode), .busy(busy)
   );

   function automatic logic [11:0] obs_vec();
      return {cur_mode, busy, core_clk_en, pll_en, snoop_en, lowv_req,
              core_sw_en, iso_en, ret_save, ret_restore};
   endfunction

   function automatic logic [11:0] model_vec();
      return {m_mode, m_busy, m_core, m_pll, m_snoop, m_lowv, m_sw, m_iso, m_save, m_rest};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_ev(input string tag);
      ev_t e;
      e.vec = model_vec();
      e.tag = tag;
      evq.push_back(e);
   endtask

   // expected sequence of output snapshots for one accepted request
   task automatic plan_path(input logic [1:0] from, input logic [1:0] to);
      int lvl = int'(from);
      m_busy = 1'b1; push_ev("R8 busy rise");
      while (lvl < int'(to)) begin
         case (lvl)
            0: begin m_core = 1'b0; push_ev("R2 core clock stop"); end
            1: begin
               m_pll = 1'b0; m_snoop = 1'b0; push_ev("R3 pll/snoop stop");
               m_lowv = 1'b1; push_ev("R3 low voltage request");
            end
            default: begin
               m_iso = 1'b1; push_ev("R4 isolation on");
               m_save = 1'b1; push_ev("R4 save pulse");
               m_save = 1'b0; m_sw = 1'b0; push_ev("R4 switch open");
            end
         endcase
         lvl++;
      end
      while (lvl > int'(to)) begin
         case (lvl)
            3: begin
               m_sw = 1'b1; push_ev("R5 switch close");
               m_rest = 1'b1; push_ev("R5 restore pulse");
               m_rest = 1'b0; m_iso = 1'b0; push_ev("R5 isolation off");
            end
            2: begin
               m_lowv = 1'b0; push_ev("R5 nominal voltage");
               m_pll = 1'b1; m_snoop = 1'b1; push_ev("R5 pll/snoop start");
            end
            default: begin m_core = 1'b1; push_ev("R5 core clock start"); end
         endcase
         lvl--;
      end
      m_busy = 1'b0; m_mode = to; push_ev("R10 done and mode update");
   endtask

   // driver: one-cycle request, expected items pushed if it should be taken
   task automatic request(input logic [1:0] m);
      @(negedge clk); #1;
      if (evq.size() == 0 && m != m_mode) plan_path(m_mode, m);
      req_valid = 1'b1;
      req_mode  = m;
      @(negedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (evq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic go(input logic [1:0] m);
      request(m);
      wait_idle();
      chk(cur_mode == m_mode, "R8", "final mode", int'(cur_mode), int'(m_mode));
      chk(busy == 1'b0, "R8", "busy after walk", int'(busy), 0);
   endtask

   // acknowledge responder: one pulse per clock or supply output change
   int  ccnt, pcnt;
   bit  p_core, p_pll, p_lowv, p_sw, p_up;
   always @(negedge clk) begin
      if (!rst_n) begin
         clk_ack <= 1'b0; pwr_ack <= 1'b0; ccnt <= 0; pcnt <= 0; p_up <= 1'b0;
         p_core <= 1'b1; p_pll <= 1'b1; p_lowv <= 1'b0; p_sw <= 1'b1;
      end else begin
         clk_ack <= 1'b0;
         pwr_ack <= 1'b0;
         if (core_clk_en != p_core || pll_en != p_pll) ccnt <= ack_dly;
         else if (ccnt > 0) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) clk_ack <= 1'b1;
         end
         if (lowv_req != p_lowv || core_sw_en != p_sw) begin
            pcnt <= ack_dly;
            p_up <= core_sw_en && !p_sw;
         end else if (pcnt > 0) begin
            pcnt <= pcnt - 1;
            if (pcnt == 1) begin
               pwr_ack <= 1'b1;
               if (p_up) sw_ack_cyc <= cyc;
            end
         end
         p_core <= core_clk_en; p_pll <= pll_en; p_lowv <= lowv_req; p_sw <= core_sw_en;
      end
   end

   // monitor: every output change must match the next expected item
   logic [11:0] prev_obs;
   always @(negedge clk) begin
      logic [11:0] o;
      o = obs_vec();
      if (mon_en && o != prev_obs) begin
         if (evq.size() == 0) begin
            chk(1'b0, "R9", "unexpected output change", int'(o), int'(prev_obs));
         end else begin
            ev_t e;
            e = evq.pop_front();
            chk(o == e.vec, e.tag, "output snapshot", int'(o), int'(e.vec));
         end
         if (ret_restore && !prev_obs[0])
            chk((cyc - sw_ack_cyc) == int'(settle_val) + SYNC + 2, "R6", "settle latency",
                cyc - sw_ack_cyc, int'(settle_val) + SYNC + 2);
      end
      prev_obs = o;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; settle_val = 8'd5;
      m_mode = 2'd0; m_busy = 1'b0; m_core = 1'b1; m_pll = 1'b1; m_snoop = 1'b1;
      m_lowv = 1'b0; m_sw = 1'b1; m_iso = 1'b0; m_save = 1'b0; m_rest = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(obs_vec() == model_vec(), "R1", "reset outputs", int'(obs_vec()), int'(model_vec()));
      chk(cur_mode == 2'd0, "R1", "reset mode", int'(cur_mode), 0);
      mon_en = 1'b1;

      // single-level steps down and a full wake
      go(2'd1);
      go(2'd2);
      go(2'd3);
      go(2'd0);

      // R7: a slow acknowledge stalls the walk
      ack_dly = 30;
      request(2'd1);
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R7", "busy while ack pending", int'(busy), 1);
      chk(cur_mode == 2'd0, "R7", "mode held while ack pending", int'(cur_mode), 0);
      chk(core_clk_en == 1'b0 && pll_en == 1'b1, "R7", "no step past clock stop",
          int'({core_clk_en, pll_en}), 1);
      wait_idle();
      go(2'd0);

      // R10 direct jump with zero settle, R9 stray request while busy
      ack_dly = 1; settle_val = 8'd0;
      request(2'd3);
      repeat (4) @(negedge clk);
      request(2'd1);
      wait_idle();
      chk(cur_mode == 2'd3, "R9", "busy request ignored", int'(cur_mode), 3);
      request(2'd3);
      repeat (15) @(negedge clk);
      chk(busy == 1'b0, "R9", "same-mode request ignored", int'(busy), 0);

      // more settle values and mixed paths
      settle_val = 8'd12; ack_dly = 2;
      go(2'd2);
      go(2'd0);
      go(2'd2);
      go(2'd1);
      settle_val = 8'd1;
      go(2'd3);
      go(2'd1);
      go(2'd0);

      chk(evq.size() == 0, "R10", "all expected items seen", evq.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule